// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings up and tears down the supply rails of a flat panel in a fixed order, one rail at a time. Power-up raises the logic supply, then the data signals, then the bias voltage, then the panel enable. Power-down lowers them in the opposite order. Between two rail changes the block waits for a programmable number of display frames. It measures frames by polling a vertical-sync status level once per clock cycle.

Each frame wait has two phases. First it waits for the sync level to be seen low, then it waits for it to be seen high. Either phase gives up after a bounded number of polls and moves on, so a dead sync source cannot hang the panel. Control is two request pulses, one for on and one for off. Status is a busy level and a one-cycle done strobe. There is no data stream, so no port uses a handshake: requests are sampled on the clock edge and are never back-pressured. A request that cannot act at once is either latched or dropped, as the requirements below state.

Top module: `panel_pwr_seq`

## Requirements
- R1: On power-up the rails rise one per step in the order `rail_en[0]` (logic supply), `rail_en[1]` (data signals), `rail_en[2]` (bias), `rail_en[3]` (panel enable). Between steps `rail_en` always holds a value of the form 0..01..1.
- R2: On power-down the rails fall in reverse: `rail_en[3]` first and `rail_en[0]` last, one per step.
- R3: After every rail change the block waits `FRAMES_PER_STEP` frames before the next change. A frame ends at the first cycle in which `vsync_active` is seen high after it has been seen low (or after the low-wait has timed out). With a one-cycle sync pulse every P cycles (2 ≤ P ≤ `POLL_LIMIT`), consecutive changes are `FRAMES_PER_STEP`·P cycles apart.
- R4: Each of the two waits inside a frame ends after at most `POLL_LIMIT` polls (one poll per cycle), even if the awaited level never appears. With `vsync_active` stuck low or stuck high, each frame lasts `POLL_LIMIT`+1 cycles.
- R5: The last rail change of a sequence is also followed by the full frame wait. Only then does `done` pulse for one cycle. When `done` is high, `busy` is low and the rails are all high or all low.
- R6: A request sampled on a clock edge changes the first rail on that same edge. `busy` is high from that edge until the edge on which `done` rises.
- R7: A request that matches the settled state (on while all rails are high, off while all are low) pulses `done` one cycle later. It leaves the rails unchanged and never raises `busy`.
- R8: A request for the opposite direction that arrives while busy is remembered. The reverse sequence starts its first rail change one cycle after the current sequence's `done`.
- R9: A request for the same direction that arrives while busy is ignored. No second sequence runs and no extra `done` appears.
- R10: When `pwr_on_req` and `pwr_off_req` are both high while idle, the off request wins.
- R11: Reset (`rst_n` low, asynchronous) drives all rails low immediately, including in the middle of a sequence. It also clears `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sync poll per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request a power-up sequence |
| pwr_off_req | input | 1 | Request a power-down sequence |
| vsync_active | input | 1 | Vertical-sync status level, high while sync is active |
| rail_en | output | NUM_RAILS | Rail enables, bit 0 = logic supply, bit 3 = panel enable |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle strobe when a request has been completed |

## Verification
The bench uses a small poll limit and sweeps the sync input through three patterns: stuck low, stuck high, and a one-cycle pulse at every period from 2 up to the poll limit. For each pattern it times every gap between rail changes in both directions. A design that counted frames on the wrong phase, skipped the wait after the last rail, or let the timeout count run one poll too long or too short would shift these gaps by a cycle or by a whole frame.

The bench also targets request handling. It issues an opposite request mid-sequence, which a design that drops it would never service. It issues a same-direction request mid-sequence, which a design that queues it would answer with an extra strobe. It issues a request for the state already reached, which a faulty design would answer by raising busy. It asserts both requests together, where a design with the wrong priority would power up. Finally it resets mid-sequence, where rails that stay high would show a synchronous or missing reset.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_STEP = 1'b1
  } seq_state_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } seq_dir_t;

  // Width needed to hold values 0..n-1, never below one bit.
  function automatic int unsigned bits_for(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pps_frame_timer.sv
module pps_frame_timer #(
  parameter int unsigned POLL_LIMIT      = 10000,
  parameter int unsigned FRAMES_PER_STEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic vsync_active,
  output logic fin
);
  import pps_pkg::*;

  localparam int unsigned PW = bits_for(POLL_LIMIT);
  localparam int unsigned FW = bits_for(FRAMES_PER_STEP);
  localparam logic [PW-1:0] POLL_LAST  = PW'(POLL_LIMIT - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAMES_PER_STEP - 1);

  logic          waiting_active;  // 0: await low level, 1: await high level
  logic [PW-1:0] poll_cnt;
  logic [FW-1:0] frame_cnt;
  logic          level_seen;
  logic          timed_out;
  logic          phase_end;

  always_comb begin
    level_seen = waiting_active ? vsync_active : !vsync_active;
    timed_out  = (poll_cnt == POLL_LAST);
    phase_end  = run && (level_seen || timed_out);
    fin        = phase_end && waiting_active && (frame_cnt == FRAME_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_active <= 1'b0;
      poll_cnt       <= '0;
      frame_cnt      <= '0;
    end else if (!run) begin
      waiting_active <= 1'b0;
      poll_cnt       <= '0;
      frame_cnt      <= '0;
    end else if (phase_end) begin
      poll_cnt <= '0;
      if (!waiting_active) begin
        waiting_active <= 1'b1;
      end else begin
        waiting_active <= 1'b0;
        frame_cnt      <= fin ? '0 : frame_cnt + 1'b1;
      end
    end else begin
      poll_cnt <= poll_cnt + 1'b1;
    end
  end

  // R4: a poll phase never exceeds its limit
  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= POLL_LAST);

  // R3: leaving the high-wait needs a high sample or a timeout
  assert_active_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $fell(waiting_active))
      |-> ($past(vsync_active) || $past(poll_cnt) == POLL_LAST));

  // R3: entering the high-wait needs a low sample or a timeout
  assert_inactive_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $rose(waiting_active))
      |-> (!$past(vsync_active) || $past(poll_cnt) == POLL_LAST));

endmodule

// File: rtl/pps_rail_bank.sv
module pps_rail_bank #(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned IW        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apply,
  input  logic [IW-1:0]        idx,
  input  logic                 level,
  output logic [NUM_RAILS-1:0] rail_en
);

  logic [NUM_RAILS-1:0] rail_q;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rail_q[g] <= 1'b0;
      else if (apply && (idx == IW'(g)))
        rail_q[g] <= level;
    end
  end

  assign rail_en = rail_q;

  // R1/R2: rails stay a contiguous run of ones from bit 0
  assert_thermo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & NUM_RAILS'(rail_en + 1'b1)) == '0);

  // R3: never more than one rail moves per edge
  assert_single_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en ^ $past(rail_en)) <= 1);

endmodule

// File: rtl/pps_seq_ctrl.sv
module pps_seq_ctrl #(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned IW        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_on,
  input  logic                 req_off,
  input  logic                 frame_fin,
  input  logic [NUM_RAILS-1:0] rail_en,
  output logic                 apply,
  output logic [IW-1:0]        idx,
  output logic                 level,
  output logic                 busy,
  output logic                 done
);
  import pps_pkg::*;

  localparam logic [IW-1:0] IDX_TOP = IW'(NUM_RAILS - 1);

  seq_state_t    state_q;
  seq_dir_t      dir_q;
  seq_dir_t      pend_dir_q;
  seq_dir_t      want_dir;
  logic          pend_q;
  logic [IW-1:0] idx_q;
  logic          done_q;

  logic all_on, all_off, want, already, start, match_done;
  logic at_last, advance, finish, opposite;
  logic [IW-1:0] first_idx, next_idx;

  always_comb begin
    all_on     = &rail_en;
    all_off    = ~|rail_en;
    want       = pend_q || req_on || req_off;
    if (pend_q)       want_dir = pend_dir_q;
    else if (req_off) want_dir = DIR_DOWN;   // off wins a tie
    else              want_dir = DIR_UP;
    already    = (want_dir == DIR_UP) ? all_on : all_off;
    start      = (state_q == SEQ_IDLE) && want && !already;
    match_done = (state_q == SEQ_IDLE) && want && already;

    at_last    = (dir_q == DIR_UP) ? (idx_q == IDX_TOP) : (idx_q == '0);
    advance    = (state_q == SEQ_STEP) && frame_fin && !at_last;
    finish     = (state_q == SEQ_STEP) && frame_fin && at_last;
    opposite   = (state_q == SEQ_STEP) && ((dir_q == DIR_UP) ? req_off : req_on);

    first_idx  = (want_dir == DIR_UP) ? '0 : IDX_TOP;
    next_idx   = (dir_q == DIR_UP) ? idx_q + 1'b1 : idx_q - 1'b1;

    apply      = start || advance;
    idx        = start ? first_idx : next_idx;
    level      = start ? (want_dir == DIR_UP) : (dir_q == DIR_UP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      dir_q      <= DIR_UP;
      pend_q     <= 1'b0;
      pend_dir_q <= DIR_UP;
      idx_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= finish || match_done;
      if (start) begin
        state_q <= SEQ_STEP;
        dir_q   <= want_dir;
      end else if (finish) begin
        state_q <= SEQ_IDLE;
      end
      if (apply)
        idx_q <= idx;
      if ((state_q == SEQ_IDLE) && want) begin
        pend_q <= 1'b0;
      end else if (opposite) begin
        pend_q     <= 1'b1;
        pend_dir_q <= (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
      end
    end
  end

  assign busy = (state_q == SEQ_STEP);
  assign done = done_q;

  // R5: completion only reported in a settled, idle state
  assert_done_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (all_on || all_off)));

  // R6: a rail only moves on an edge that leaves the block busy
  assert_busy_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rail_en) |-> busy);

  // R7: idle without a start keeps every rail where it is
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_IDLE) && !apply) |=> $stable(rail_en));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int unsigned NUM_RAILS       = 4,
  parameter int unsigned FRAMES_PER_STEP = 4,
  parameter int unsigned POLL_LIMIT      = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_on_req,
  input  logic                 pwr_off_req,
  input  logic                 vsync_active,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 busy,
  output logic                 done
);
  import pps_pkg::*;

  localparam int unsigned IW = bits_for(NUM_RAILS);

  logic          frame_fin;
  logic          apply;
  logic [IW-1:0] step_idx;
  logic          step_level;

  pps_seq_ctrl #(.NUM_RAILS(NUM_RAILS), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_on    (pwr_on_req),
    .req_off   (pwr_off_req),
    .frame_fin (frame_fin),
    .rail_en   (rail_en),
    .apply     (apply),
    .idx       (step_idx),
    .level     (step_level),
    .busy      (busy),
    .done      (done)
  );

  pps_frame_timer #(.POLL_LIMIT(POLL_LIMIT), .FRAMES_PER_STEP(FRAMES_PER_STEP)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (busy),
    .vsync_active (vsync_active),
    .fin          (frame_fin)
  );

  pps_rail_bank #(.NUM_RAILS(NUM_RAILS), .IW(IW)) u_rails (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply   (apply),
    .idx     (step_idx),
    .level   (step_level),
    .rail_en (rail_en)
  );

endmodule

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;
  localparam int N = 4;
  localparam int F = 4;
  localparam int L = 8;
  localparam int STUCK = F * (L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0;
  logic vsync = 1'b0;
  logic [N-1:0] rail;
  logic busy, done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int vmode = 0, vper = 4, vcnt = 0;

  panel_pwr_seq #(.NUM_RAILS(N), .FRAMES_PER_STEP(F), .POLL_LIMIT(L)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(req_on), .pwr_off_req(req_off),
    .vsync_active(vsync), .rail_en(rail), .busy(busy), .done(done));

  always #4 clk = ~clk;

  // sync source: 0 stuck low, 1 stuck high, 2 one-cycle pulse every vper
  always @(negedge clk) begin
    vcnt  <= (vcnt >= vper - 1) ? 0 : vcnt + 1;
    vsync <= (vmode == 1) ? 1'b1 : (vmode == 0) ? 1'b0 : (vcnt == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [N-1:0] therm(int k);
    return N'((1 << k) - 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(bit on, bit off);
    @(negedge clk); req_on = on; req_off = off;
    @(negedge clk); req_on = 1'b0; req_off = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!done && gap < 3000);
  endtask

  // Runs one sequence and times every rail change and the final done.
  task automatic run_seq(bit up, int lo, int hi, int flo, int fhi,
                         int inj_at, bit inj_on, bit inj_off);
    int s, gap, total;
    logic [N-1:0] exp_v;
    string ord;
    ord = up ? "R1 order" : "R2 order";
    pulse(up, !up);
    exp_v = up ? therm(1) : therm(N - 1);
    chk(rail == exp_v, "R6 first rail on sampling edge", rail, exp_v);
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
    s = 1; gap = 0; total = 0;
    while (s <= N) begin
      @(negedge clk); gap++; total++;
      if (total == inj_at) begin req_on = inj_on; req_off = inj_off; end
      else if (total == inj_at + 1) begin req_on = 1'b0; req_off = 1'b0; end
      if (done) begin
        chk(s == N, "R5 done after last rail", s, N);
        chk(gap >= lo && gap <= hi, "R5 R3 R4 wait after last rail", gap, lo);
        chk(busy == 1'b0, "R5 busy low with done", busy, 0);
        exp_v = up ? therm(N) : therm(0);
        chk(rail == exp_v, "R5 settled rails", rail, exp_v);
        s = N + 1;
      end else if (rail != (up ? therm(s) : therm(N - s))) begin
        s++;
        exp_v = up ? therm(s) : therm(N - s);
        chk(rail == exp_v, ord, rail, exp_v);
        if (s == 2) chk(gap >= flo && gap <= fhi, "R3 R4 first step gap", gap, flo);
        else        chk(gap >= lo && gap <= hi, "R3 R4 step gap", gap, lo);
        gap = 0;
      end else if (gap > 3000) begin
        chk(1'b0, "R3 sequence stalled", gap, lo);
        s = N + 1;
      end
    end
    req_on = 1'b0; req_off = 1'b0;
  endtask

  initial begin
    int g, seen;
    idle(3);
    chk(rail == '0, "R11 rails low in reset", rail, 0);
    chk(busy == 1'b0, "R11 busy low in reset", busy, 0);
    chk(done == 1'b0, "R11 done low in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R10: both requests from all-off -> off wins, already settled
    pulse(1'b1, 1'b1);
    chk(done == 1'b1, "R10 both requests treated as off", done, 1);
    chk(rail == '0, "R10 rails stay low", rail, 0);
    chk(busy == 1'b0, "R7 no busy on matching request", busy, 0);
    idle(3);

    // stuck low: every frame times out in the high-wait
    vmode = 0; idle(4);
    run_seq(1'b1, STUCK, STUCK, STUCK, STUCK, 0, 1'b0, 1'b0);
    idle(3);
    pulse(1'b1, 1'b0);
    chk(done == 1'b1, "R7 done on repeated on", done, 1);
    chk(rail == therm(N), "R7 rails unchanged", rail, therm(N));
    chk(busy == 1'b0, "R7 busy stays low", busy, 0);
    idle(3);
    run_seq(1'b0, STUCK, STUCK, STUCK, STUCK, 0, 1'b0, 1'b0);
    idle(3);

    // stuck high: every frame times out in the low-wait
    vmode = 1; idle(4);
    run_seq(1'b1, STUCK, STUCK, STUCK, STUCK, 0, 1'b0, 1'b0);
    idle(3);
    pulse(1'b1, 1'b1);
    chk(rail == therm(N - 1), "R10 both requests power down", rail, therm(N - 1));
    wait_done(g);
    chk(rail == '0, "R10 down sequence completes", rail, 0);
    idle(3);

    // pulse sweep over every period up to the poll limit
    vmode = 2;
    for (int p = 2; p <= L; p++) begin
      vper = p; idle(2 * L);
      run_seq(1'b1, F * p, F * p, (F - 1) * p + 1, F * p + 1, 0, 1'b0, 1'b0);
      idle(3);
      run_seq(1'b0, F * p, F * p, (F - 1) * p + 1, F * p + 1, 0, 1'b0, 1'b0);
      idle(3);
    end

    // R8: opposite request mid-sequence is served right after done
    vmode = 0; idle(4);
    run_seq(1'b1, STUCK, STUCK, STUCK, STUCK, 10, 1'b0, 1'b1);
    @(negedge clk);
    chk(rail == therm(N - 1), "R8 reverse starts after done", rail, therm(N - 1));
    chk(busy == 1'b1, "R8 busy for reverse", busy, 1);
    wait_done(g);
    chk(rail == '0, "R8 reverse sequence completes", rail, 0);
    idle(3);

    // R9: same-direction request mid-sequence is dropped
    run_seq(1'b1, STUCK, STUCK, STUCK, STUCK, 10, 1'b1, 1'b0);
    seen = 0;
    for (int i = 0; i < 3 * STUCK; i++) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    chk(seen == 0, "R9 no extra sequence or done", seen, 0);
    chk(rail == therm(N), "R9 rails remain on", rail, therm(N));

    // R11: reset in the middle of a power-down
    pulse(1'b0, 1'b1);
    idle(5);
    #1 rst_n = 1'b0;
    #1;
    chk(rail == '0, "R11 async reset clears rails", rail, 0);
    chk(busy == 1'b0, "R11 async reset clears busy", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    chk(rail == '0 && done == 1'b0, "R11 idle after reset", rail, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule